// File: doc/BRIEF.md
# Multiplexed external bus cycle sequencer

This block produces the external memory bus cycles of a small 8-bit controller whose low address byte and data byte share one set of pins. It runs from the oscillator clock, so every strobe edge falls on a whole oscillator period. A request names one of three cycle kinds: a program fetch, a data read or a data write. The block then raises the address latch strobe, drives the low address byte on the shared pins and the high byte on a separate output. It then opens either the program strobe or the read or write strobe, and it captures or drives the data byte.

The controller is a single state machine. Its states are `ST_IDLE` (bus quiet), `ST_ALE` (latch strobe high, low address driven), `ST_AHOLD` (latch strobe low, address still driven), `ST_SETUP` (data cycles only; a write drives its data in the last period), `ST_STROBE` (program, read or write strobe low) and `ST_RECOV` (data cycles only; strobe released, write data still held). The transitions are:
- IDLE to ALE on an accepted request.
- ALE to AHOLD after the latch strobe width.
- AHOLD to STROBE for a fetch, or AHOLD to SETUP for a data cycle.
- SETUP to STROBE.
- STROBE to IDLE for a fetch, or STROBE to RECOV for a data cycle.
- RECOV to IDLE, or RECOV to ALE when a request is waiting.

A one-cycle completion pulse is raised together with the captured byte.

Top module: `xbus_seq`

## Requirements
- R1: Out of reset and whenever idle, `ale` is 0, `psen_n`, `rd_n` and `wr_n` are 1, `ad_oe` is 0 and `done` is 0.
- R2: A request accepted at a clock edge makes `ale` high for the 2 periods that follow (k=0,1, k counting periods from that edge). `ad_oe` is 1 and `ad_out` is the request's address bits [7:0] for k=0..2. `ah_out` shows address bits [15:8] from k=0 on and keeps them after the cycle.
- R3: A fetch (`req_data`=0) holds `psen_n` low for k=3..5 only. `rd_n` and `wr_n` stay high.
- R4: A data read (`req_data`=1, `req_wr`=0) holds `rd_n` low for k=5..10. A data write (`req_data`=1, `req_wr`=1) holds `wr_n` low for k=5..10. `psen_n` stays high in both.
- R5: `ad_oe` is 0 from k=3 to the end of a fetch or read, so the pins are released before `psen_n` or `rd_n` falls.
- R6: `ad_in` is sampled at the edge that ends the last strobe-low period. `done` is high for exactly one period, k=6 for a fetch and k=11 for a read, with `rdata` holding the sampled byte.
- R7: In a write, `ad_oe` is 1 and `ad_out` is the write byte for k=4..11. `done` pulses at k=11 and `rdata` keeps its previous value.
- R8: A request present during k=11 of a data cycle is accepted, so `ale` rises again at k=12, one period after `rd_n` or `wr_n` rises.
- R9: A request present while a cycle is in progress (k=0..10 of a data cycle, k=0..5 of a fetch) is ignored. It does not change the running cycle's address, kind or data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_data | input | 1 | 0 = program fetch, 1 = data cycle |
| req_wr | input | 1 | In a data cycle, 1 = write, 0 = read |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write byte |
| ad_in | input | 8 | Shared pins as read back |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program fetch strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Value driven on the shared pins |
| ad_oe | output | 1 | Shared pins driven when 1 |
| ah_out | output | 8 | High address byte |
| done | output | 1 | One-period completion pulse |
| rdata | output | 8 | Captured fetch or read byte |

## Verification
The assertions assume the default timing parameters. In particular, they rely on a latch strobe at least two periods wide and on fetch and data strobes that never overlap the latch strobe. They also assume a clean reset, with no request counted before reset is released. The directed stimulus uses only the default parameters. Every request is raised at a falling edge, and it is either dropped after one rising edge or deliberately held through busy states to show that it is ignored. The bench lowers a request held through a busy stretch before the sequencer can accept requests again, so each check sees exactly one cycle.

// File: rtl/xbus_seq_pkg.sv
package xbus_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALE,
        ST_AHOLD,
        ST_SETUP,
        ST_STROBE,
        ST_RECOV
    } xbus_state_t;

    typedef enum logic [1:0] {
        K_FETCH,
        K_READ,
        K_WRITE
    } xbus_kind_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/xbus_seq_fsm.sv
module xbus_seq_fsm
    import xbus_seq_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int ALE_CYC     = 2,
    parameter int FETCH_WIDTH = 3,
    parameter int DATA_LEAD   = 3,
    parameter int DATA_WIDTH  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_data,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output xbus_state_t       state,
    output xbus_kind_t        kind,
    output logic              last,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);
    localparam int MAX_DUR = imax(imax(ALE_CYC, FETCH_WIDTH), imax(DATA_LEAD, DATA_WIDTH));
    localparam int CNT_W   = $clog2(MAX_DUR) + 1;

    xbus_state_t      st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             accept;
    xbus_kind_t       kind_n;

    assign last   = (cnt == '0);
    // requests are taken only when idle or in the write/read recovery period (R8, R9)
    assign accept = req_valid && (state == ST_IDLE || state == ST_RECOV);
    assign kind_n = req_data ? (req_wr ? K_WRITE : K_READ) : K_FETCH;

    always_comb begin
        st_n  = state;
        cnt_n = cnt;
        if (accept) begin
            st_n  = ST_ALE;
            cnt_n = CNT_W'(ALE_CYC - 1);
        end else if (state != ST_IDLE && !last) begin
            cnt_n = cnt - 1'b1;
        end else begin
            unique case (state)
                ST_IDLE:  st_n = ST_IDLE;
                ST_ALE: begin
                    st_n  = ST_AHOLD;
                    cnt_n = '0;
                end
                ST_AHOLD: begin
                    if (kind == K_FETCH) begin
                        st_n  = ST_STROBE;
                        cnt_n = CNT_W'(FETCH_WIDTH - 1);
                    end else begin
                        st_n  = ST_SETUP;
                        cnt_n = CNT_W'(DATA_LEAD - 2);
                    end
                end
                ST_SETUP: begin
                    st_n  = ST_STROBE;
                    cnt_n = CNT_W'(DATA_WIDTH - 1);
                end
                ST_STROBE: begin
                    st_n  = (kind == K_FETCH) ? ST_IDLE : ST_RECOV;
                    cnt_n = '0;
                end
                ST_RECOV: st_n = ST_IDLE;
                default:  st_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            kind    <= K_FETCH;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            state <= st_n;
            cnt   <= cnt_n;
            if (accept) begin
                kind    <= kind_n;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end
    end

    // R9: the latched address holds while a cycle runs
    a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && state != ST_RECOV) |=> $stable(addr_q));
endmodule

// File: rtl/xbus_seq_out.sv
module xbus_seq_out
    import xbus_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  xbus_state_t              state,
    input  xbus_kind_t               kind,
    input  logic                     last,
    input  logic [ADDR_W-1:0]        addr_q,
    input  logic [DATA_W-1:0]        wdata_q,
    input  logic [DATA_W-1:0]        ad_in,
    output logic                     ale,
    output logic                     psen_n,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] ah_out,
    output logic                     done,
    output logic [DATA_W-1:0]        rdata
);
    logic addr_drive, wdat_drive, capture;

    always_comb begin
        addr_drive = (state == ST_ALE) || (state == ST_AHOLD);
        wdat_drive = (kind == K_WRITE) &&
                     ((state == ST_SETUP && last) || state == ST_STROBE || state == ST_RECOV);
        ale    = (state == ST_ALE);
        psen_n = !(state == ST_STROBE && kind == K_FETCH);
        rd_n   = !(state == ST_STROBE && kind == K_READ);
        wr_n   = !(state == ST_STROBE && kind == K_WRITE);
        ad_oe  = addr_drive || wdat_drive;
        ad_out = addr_drive ? addr_q[DATA_W-1:0] : (wdat_drive ? wdata_q : '0);
        ah_out = addr_q[ADDR_W-1:DATA_W];
        capture = (state == ST_STROBE) && last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= capture;
            if (capture && kind != K_WRITE) rdata <= ad_in;
        end
    end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_seq_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int ALE_CYC     = 2,
    parameter int FETCH_WIDTH = 3,
    parameter int DATA_LEAD   = 3,
    parameter int DATA_WIDTH  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_data,
    input  logic                     req_wr,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [DATA_W-1:0]        ad_in,
    output logic                     ale,
    output logic                     psen_n,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] ah_out,
    output logic                     done,
    output logic [DATA_W-1:0]        rdata
);
    xbus_state_t       state;
    xbus_kind_t        kind;
    logic              last;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    xbus_seq_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ALE_CYC(ALE_CYC),
        .FETCH_WIDTH(FETCH_WIDTH), .DATA_LEAD(DATA_LEAD), .DATA_WIDTH(DATA_WIDTH)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data),
        .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
        .state(state), .kind(kind), .last(last), .addr_q(addr_q), .wdata_q(wdata_q)
    );

    xbus_seq_out #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_out (
        .clk(clk), .rst_n(rst_n), .state(state), .kind(kind), .last(last),
        .addr_q(addr_q), .wdata_q(wdata_q), .ad_in(ad_in),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .ad_out(ad_out), .ad_oe(ad_oe), .ah_out(ah_out), .done(done), .rdata(rdata)
    );

    // R2: latch strobe lasts at least two periods and always carries the address
    a_r2_ale_two: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |=> ale);
    a_r2_ale_drives: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ad_oe);
    // R3/R4: at most one strobe low, never together with the latch strobe
    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({!psen_n, !rd_n, !wr_n}) <= 1) && (!(psen_n && rd_n && wr_n) -> !ale));
    // R5: pins released while the program or read strobe is low
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!psen_n || !rd_n) |-> !ad_oe);
    // R6: completion pulse accompanies the strobe release and lasts one period
    a_r6_done_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(psen_n) |-> done);
    a_r6_done_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> done);
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: write byte driven throughout the write strobe
    a_r7_wr_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);
endmodule

// File: tb/test_xbus_seq.sv
module test_xbus_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_data = 1'b0, req_wr = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0, ad_in = '0;
    logic        ale, psen_n, rd_n, wr_n, ad_oe, done;
    logic [7:0]  ad_out, ah_out, rdata;

    int checks = 0;
    int failures = 0;
    logic [7:0] last_rb = 8'h00;

    always #10 clk = ~clk;

    xbus_seq i_xbus_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data),
        .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata), .ad_in(ad_in),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out),
        .ad_oe(ad_oe), .ah_out(ah_out), .done(done), .rdata(rdata)
    );

    task automatic chk(input string r, input string what, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s got=%h exp=%h at %0t", r, what, got, exp, $time);
        end
    endtask

    task automatic chk_idle(input string r);
        chk(r, "ale", 16'(ale), 16'd0);
        chk(r, "strobes", 16'({psen_n, rd_n, wr_n}), 16'h7);
        chk(r, "ad_oe", 16'(ad_oe), 16'd0);
        chk(r, "done", 16'(done), 16'd0);
    endtask

    // one bus cycle; k counts periods from the accepting edge
    task automatic do_cycle(input bit dat, input bit wr, input logic [15:0] a,
                            input logic [7:0] wd, input logic [7:0] rb,
                            input bit launched, input bit poke, input bit chain,
                            input logic [15:0] na, input bit ndat, input bit nwr);
        int  len, cap_k, done_k;
        bit  oe_e, dr_e;
        logic [7:0] rd_e;
        string ra;
        len    = dat ? 12 : 7;
        cap_k  = dat ? 10 : 5;
        done_k = dat ? 11 : 6;
        rd_e   = (dat && wr) ? last_rb : rb;
        ra     = poke ? "R9" : "R2";
        if (!launched) begin
            req_valid = 1'b1; req_data = dat; req_wr = wr; req_addr = a; req_wdata = wd;
            @(negedge clk);
        end
        for (int k = 0; k < len; k++) begin
            if (k == 0) req_valid = 1'b0;
            if (poke && k == 1) begin
                req_valid = 1'b1; req_data = !dat; req_wr = 1'b1;
                req_addr = ~a; req_wdata = ~wd;
            end
            if (poke && k == 4) req_valid = 1'b0;
            ad_in = (k == cap_k) ? rb : ~rb;
            chk(launched ? "R8" : "R2", "ale", 16'(ale), 16'(k < 2));
            chk(ra, "ah_out", 16'(ah_out), 16'(a[15:8]));
            dr_e = dat && wr && k >= 4 && k <= 11;
            oe_e = (k <= 2) || dr_e;
            chk(dr_e ? "R7" : "R5", "ad_oe", 16'(ad_oe), 16'(oe_e));
            if (k <= 2) chk(ra, "ad_out addr", 16'(ad_out), 16'(a[7:0]));
            else if (dr_e) chk(poke ? "R9" : "R7", "ad_out wdata", 16'(ad_out), 16'(wd));
            chk(poke ? "R9" : "R3", "psen_n", 16'(psen_n), 16'(!(!dat && k >= 3 && k <= 5)));
            chk(poke ? "R9" : "R4", "rd_n", 16'(rd_n), 16'(!(dat && !wr && k >= 5 && k <= 10)));
            chk(poke ? "R9" : "R4", "wr_n", 16'(wr_n), 16'(!(dat && wr && k >= 5 && k <= 10)));
            chk(wr ? "R7" : "R6", "done", 16'(done), 16'(k == done_k));
            if (k == done_k) chk(wr ? "R7" : "R6", "rdata", 16'(rdata), 16'(rd_e));
            if (chain && k == len - 1) begin
                req_valid = 1'b1; req_data = ndat; req_wr = nwr; req_addr = na; req_wdata = 8'h5A;
            end
            @(negedge clk);
        end
        last_rb = rd_e;
        if (!chain) chk_idle(poke ? "R9" : "R1");
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1");
        chk("R1", "rdata", 16'(rdata), 16'h00);
    endtask

    task automatic t_fetch;
        do_cycle(1'b0, 1'b0, 16'h12C4, 8'h00, 8'h3B, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0);
        do_cycle(1'b0, 1'b1, 16'hFF00, 8'h00, 8'hE1, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0);
    endtask

    task automatic t_read;
        do_cycle(1'b1, 1'b0, 16'h8001, 8'h00, 8'h7E, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0);
    endtask

    task automatic t_write;
        do_cycle(1'b1, 1'b1, 16'h0AB5, 8'hC3, 8'h99, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0);
    endtask

    task automatic t_ignore;
        do_cycle(1'b0, 1'b0, 16'h3366, 8'h00, 8'h42, 1'b0, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0);
        do_cycle(1'b1, 1'b0, 16'hA55A, 8'h0F, 8'hD2, 1'b0, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0);
    endtask

    task automatic t_chain;
        // R8: read then fetch back to back, then write then write
        do_cycle(1'b1, 1'b0, 16'h4410, 8'h00, 8'h18, 1'b0, 1'b0, 1'b1, 16'h7788, 1'b0, 1'b0);
        do_cycle(1'b0, 1'b0, 16'h7788, 8'h00, 8'hB4, 1'b1, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0);
        do_cycle(1'b1, 1'b1, 16'h0102, 8'h6D, 8'h00, 1'b0, 1'b0, 1'b1, 16'hF0F1, 1'b1, 1'b1);
        do_cycle(1'b1, 1'b1, 16'hF0F1, 8'h5A, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_fetch();
        t_read();
        t_write();
        t_ignore();
        t_chain();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #4_000_000;
        checks++;
        failures++;
        $display("FAIL watchdog expired before the directed tests ended");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule